// File: doc/BRIEF.md
# Contactless Card Selection State Machine

This block is the command interpreter at the heart of a proximity card with a seven-byte serial number resolved over two cascade levels. A receive front end hands it frames that are already decoded. Each byte arrives with a strobe. An end-of-frame strobe follows, and it carries a single flag that says whether the parity and CRC of the frame were good. The block walks the card through the stages of being found: waiting, resolving the first and second halves of the serial number, selected, and parked after a halt. For every frame it decides whether the card answers and with what.

An answer is a whole descriptor presented in the cycle after the frame ends. It gives the byte count and up to five bytes, with the first byte to transmit in the lowest lane. The possible answers are the request acknowledgement, a fragment of the serial number with its check byte, or a select acknowledgement. Reads and writes that arrive while the card is selected are not answered here. They are handed to the memory block through a one-cycle request carrying the operation and the address byte. The serial number is a parameter, and the check bytes are derived from it.

Top module: `card_select_fsm`

## Requirements
- R1: While reset is held and after it is released, `state` is 0 (waiting), and `rsp_valid` and `mem_req` are low. The state encodings are: 0 waiting, 1 level-one resolve, 2 level-two resolve, 3 selected, 4 parked.
- R2: In state 0, a good one-byte frame 26h or 52h moves the card to state 1. The answer is two bytes: 44h first, then 00h. Any other frame leaves state 0 with no answer.
- R3: In state 1, a frame 93h followed by a count byte from 20h to 67h keeps state 1. Consider the five-byte sequence 88h, SN0, SN1, SN2, BCC0, where BCC0 is the XOR of the first four. The card answers with that sequence starting at index (count[6:4] − 2), and the length is the remainder of the sequence.
- R4: In state 1, the frame 93h 70h answers one byte 04h and moves the card to state 2.
- R5: In state 2, frame 95h with a count byte from 20h to 67h answers from the sequence SN3, SN4, SN5, SN6, BCC1 by the same rule as R3. The frame 95h 70h answers one byte 00h and moves the card to state 3.
- R6: In state 1 or 2, the frame 30h 00h moves the card to state 3 and raises `mem_req` as a read of address 0, with no answer.
- R7: In state 3, a frame starting 30h or A2h raises `mem_req` for one cycle. `mem_write` is 0 for 30h and 1 for A2h, and `mem_addr` equals the second byte. The state is unchanged and there is no answer.
- R8: In state 3, the frame 50h 00h moves the card to state 4 with no answer. In state 4 only a good one-byte 52h leaves, going to state 1 with the R2 answer. Every other frame leaves state 4 with no answer and no memory request.
- R9: In states 1 to 3, a frame that is not accepted goes to state 0, or to state 4 if the card has entered state 4 since reset. Frames not accepted include those with a bad check flag, the wrong length, or an unlisted code.
- R10: `rsp_valid` and `mem_req` are single-cycle pulses in the cycle after `rx_end`, and they are never high together.
- R11: Byte one of a frame is the command and byte two is the argument. Later bytes are ignored. The request commands need exactly one byte, and all others need at least two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| rx_valid | input | 1 | A decoded frame byte is present |
| rx_byte | input | 8 | Decoded frame byte |
| rx_end | input | 1 | Frame finished; no byte in this cycle |
| rx_ok | input | 1 | Parity and CRC of the finished frame were good |
| state | output | 3 | Selection state (encoding in R1) |
| rsp_valid | output | 1 | Answer descriptor valid |
| rsp_len | output | 3 | Number of answer bytes, 1 to 5 |
| rsp_data | output | 40 | Answer bytes, first byte in bits 7:0 |
| mem_req | output | 1 | Hand a read or write to the memory block |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 8 | Address byte of the memory command |

## Verification
Some properties are checked on every cycle. Answer and memory pulses never overlap, and each follows a frame end by exactly one cycle. The parked state is left only toward level-one resolve. The selected state is entered only from a resolve state. A card that has been halted never falls back to waiting. Other behaviour can only be shown by the bench's frame sequences: the exact answer bytes, the offset of partial fragments, the check-byte values, and the difference between error returns before and after a halt.

// File: rtl/csel_pkg.sv
package csel_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READY1 = 3'd1,
        ST_READY2 = 3'd2,
        ST_ACTIVE = 3'd3,
        ST_HALT   = 3'd4
    } sel_state_e;

    localparam int RSP_BYTES = 5;
    localparam int RSP_W     = RSP_BYTES * 8;
    localparam int LEN_W     = $clog2(RSP_BYTES + 1);

    localparam logic [7:0] OP_REQ    = 8'h26;
    localparam logic [7:0] OP_WAKE   = 8'h52;
    localparam logic [7:0] OP_LVL1   = 8'h93;
    localparam logic [7:0] OP_LVL2   = 8'h95;
    localparam logic [7:0] OP_RD     = 8'h30;
    localparam logic [7:0] OP_WR     = 8'hA2;
    localparam logic [7:0] OP_STOP   = 8'h50;
    localparam logic [7:0] CNT_SEL   = 8'h70;
    localparam logic [7:0] CNT_MIN   = 8'h20;
    localparam logic [7:0] CNT_MAX   = 8'h67;
    localparam logic [7:0] TAG_CASC  = 8'h88;
    localparam logic [7:0] ACK_LO    = 8'h44;
    localparam logic [7:0] ACK_HI    = 8'h00;
    localparam logic [7:0] SEL_MORE  = 8'h04;
    localparam logic [7:0] SEL_DONE  = 8'h00;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] arg;
        logic [1:0] cnt;   // saturates at 3
    } frame_t;

    typedef struct packed {
        sel_state_e       st;
        logic             halted;
        logic             rv;
        logic [LEN_W-1:0] rlen;
        logic [RSP_W-1:0] rdata;
        logic             mreq;
        logic             mwr;
        logic [7:0]       maddr;
    } ctl_t;
endpackage

// File: rtl/csel_frame_capture.sv
module csel_frame_capture
    import csel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_end,
    output frame_t     frame
);
    frame_t frm_d, frm_q;

    always_comb begin
        frm_d = frm_q;
        if (rx_end) begin
            frm_d = '0;
        end else if (rx_valid) begin
            if (frm_q.cnt == 2'd0) frm_d.cmd = rx_byte;
            if (frm_q.cnt == 2'd1) frm_d.arg = rx_byte;
            if (frm_q.cnt != 2'd3) frm_d.cnt = frm_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

    assign frame = frm_q;
endmodule

// File: rtl/csel_uid_frag.sv
module csel_uid_frag
    import csel_pkg::*;
#(
    parameter logic [55:0] UID = 56'h66_55_44_33_22_11_04
) (
    input  logic             level2,
    input  logic [7:0]       nvb,
    output logic             nvb_ok,
    output logic [RSP_W-1:0] data,
    output logic [LEN_W-1:0] len
);
    logic [7:0] sn [7];
    logic [7:0] bcc_lo, bcc_hi;
    logic [RSP_W-1:0] full;
    logic [2:0] known;
    logic [5:0] shamt;

    for (genvar i = 0; i < 7; i++) begin : g_sn
        assign sn[i] = UID[8*i +: 8];
    end

    assign bcc_lo = TAG_CASC ^ sn[0] ^ sn[1] ^ sn[2];
    assign bcc_hi = sn[3] ^ sn[4] ^ sn[5] ^ sn[6];

    always_comb begin
        if (level2) full = {bcc_hi, sn[6], sn[5], sn[4], sn[3]};
        else        full = {bcc_lo, sn[2], sn[1], sn[0], TAG_CASC};
        nvb_ok = (nvb >= CNT_MIN) && (nvb <= CNT_MAX);
        known  = nvb[6:4] - 3'd2;
        shamt  = {known, 3'b000};
        data   = full >> shamt;
        len    = LEN_W'(RSP_BYTES) - LEN_W'(known);
    end
endmodule

// File: rtl/card_select_fsm.sv
module card_select_fsm
    import csel_pkg::*;
#(
    parameter logic [55:0] UID = 56'h66_55_44_33_22_11_04
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_end,
    input  logic             rx_ok,
    output logic [2:0]       state,
    output logic             rsp_valid,
    output logic [LEN_W-1:0] rsp_len,
    output logic [RSP_W-1:0] rsp_data,
    output logic             mem_req,
    output logic             mem_write,
    output logic [7:0]       mem_addr
);
    frame_t           frm;
    ctl_t             ctl_d, ctl_q;
    logic             frag_ok;
    logic [RSP_W-1:0] frag_data;
    logic [LEN_W-1:0] frag_len;

    csel_frame_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_end   (rx_end),
        .frame    (frm)
    );

    csel_uid_frag #(.UID(UID)) u_frag (
        .level2 (ctl_q.st == ST_READY2),
        .nvb    (frm.arg),
        .nvb_ok (frag_ok),
        .data   (frag_data),
        .len    (frag_len)
    );

    always_comb begin
        logic       single, multi, lvl2;
        logic [7:0] casc_op;
        sel_state_e err_st;

        ctl_d       = ctl_q;
        ctl_d.rv    = 1'b0;
        ctl_d.rlen  = '0;
        ctl_d.rdata = '0;
        ctl_d.mreq  = 1'b0;
        ctl_d.mwr   = 1'b0;
        ctl_d.maddr = '0;

        single  = (frm.cnt == 2'd1);
        multi   = (frm.cnt >= 2'd2);
        lvl2    = (ctl_q.st == ST_READY2);
        casc_op = lvl2 ? OP_LVL2 : OP_LVL1;
        err_st  = ctl_q.halted ? ST_HALT : ST_IDLE;

        if (rx_end) begin
            unique case (ctl_q.st)
                ST_IDLE, ST_HALT: begin
                    if (rx_ok && single &&
                        (frm.cmd == OP_WAKE ||
                         (frm.cmd == OP_REQ && ctl_q.st == ST_IDLE))) begin
                        ctl_d.st    = ST_READY1;
                        ctl_d.rv    = 1'b1;
                        ctl_d.rlen  = LEN_W'(2);
                        ctl_d.rdata = RSP_W'({ACK_HI, ACK_LO});
                    end
                end
                ST_READY1, ST_READY2: begin
                    if (!rx_ok || !multi) begin
                        ctl_d.st = err_st;
                    end else if (frm.cmd == casc_op && frm.arg == CNT_SEL) begin
                        ctl_d.st    = lvl2 ? ST_ACTIVE : ST_READY2;
                        ctl_d.rv    = 1'b1;
                        ctl_d.rlen  = LEN_W'(1);
                        ctl_d.rdata = RSP_W'(lvl2 ? SEL_DONE : SEL_MORE);
                    end else if (frm.cmd == casc_op && frag_ok) begin
                        ctl_d.rv    = 1'b1;
                        ctl_d.rlen  = frag_len;
                        ctl_d.rdata = frag_data;
                    end else if (frm.cmd == OP_RD && frm.arg == 8'h00) begin
                        ctl_d.st   = ST_ACTIVE;
                        ctl_d.mreq = 1'b1;
                    end else begin
                        ctl_d.st = err_st;
                    end
                end
                ST_ACTIVE: begin
                    if (!rx_ok || !multi) begin
                        ctl_d.st = err_st;
                    end else if (frm.cmd == OP_RD || frm.cmd == OP_WR) begin
                        ctl_d.mreq  = 1'b1;
                        ctl_d.mwr   = (frm.cmd == OP_WR);
                        ctl_d.maddr = frm.arg;
                    end else if (frm.cmd == OP_STOP && frm.arg == 8'h00) begin
                        ctl_d.st     = ST_HALT;
                        ctl_d.halted = 1'b1;
                    end else begin
                        ctl_d.st = err_st;
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state     = ctl_q.st;
    assign rsp_valid = ctl_q.rv;
    assign rsp_len   = ctl_q.rlen;
    assign rsp_data  = ctl_q.rdata;
    assign mem_req   = ctl_q.mreq;
    assign mem_write = ctl_q.mwr;
    assign mem_addr  = ctl_q.maddr;

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && mem_req));

    assert_pulse_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req) |-> $past(rx_end));

    assert_halt_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_HALT && state != ST_HALT) |-> state == ST_READY1);

    assert_active_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && $past(state) != ST_ACTIVE) |->
        ($past(state) == ST_READY1 || $past(state) == ST_READY2));

    assert_mem_only_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> state == ST_ACTIVE);

    assert_halted_no_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.halted |-> state != ST_IDLE);
endmodule

// File: tb/card_select_fsm_bench.sv
module card_select_fsm_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_end = 1'b0;
    logic        rx_ok = 1'b0;
    logic [2:0]  state;
    logic        rsp_valid;
    logic [2:0]  rsp_len;
    logic [39:0] rsp_data;
    logic        mem_req;
    logic        mem_write;
    logic [7:0]  mem_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    card_select_fsm u_card_select_fsm (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_end(rx_end), .rx_ok(rx_ok), .state(state), .rsp_valid(rsp_valid),
        .rsp_len(rsp_len), .rsp_data(rsp_data), .mem_req(mem_req),
        .mem_write(mem_write), .mem_addr(mem_addr)
    );

    typedef struct packed {
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [1:0]  n;
        logic        ok;
        logic [2:0]  st;
        logic        rv;
        logic [2:0]  rlen;
        logic [39:0] rdata;
        logic        mreq;
        logic        mwr;
        logic [7:0]  maddr;
        logic [3:0]  req;
    } vec_t;

    // UID default: SN0..SN6 = 04 11 22 33 44 55 66, BCC0 = BFh, BCC1 = 44h
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'h26,8'h00,2'd1,1'b1,3'd1,1'b1,3'd2,40'h0000000044,1'b0,1'b0,8'h00,4'd2},  // R2
        '{8'h93,8'h20,2'd2,1'b1,3'd1,1'b1,3'd5,40'hBF22110488,1'b0,1'b0,8'h00,4'd3},  // R3
        '{8'h93,8'h40,2'd2,1'b1,3'd1,1'b1,3'd3,40'h0000BF2211,1'b0,1'b0,8'h00,4'd3},  // R3
        '{8'h93,8'h70,2'd2,1'b1,3'd2,1'b1,3'd1,40'h0000000004,1'b0,1'b0,8'h00,4'd4},  // R4
        '{8'h95,8'h20,2'd2,1'b1,3'd2,1'b1,3'd5,40'h4466554433,1'b0,1'b0,8'h00,4'd5},  // R5
        '{8'h95,8'h70,2'd2,1'b1,3'd3,1'b1,3'd1,40'h0000000000,1'b0,1'b0,8'h00,4'd5},  // R5
        '{8'h30,8'h05,2'd2,1'b1,3'd3,1'b0,3'd0,40'h0,1'b1,1'b0,8'h05,4'd7},           // R7
        '{8'h50,8'h00,2'd2,1'b1,3'd4,1'b0,3'd0,40'h0,1'b0,1'b0,8'h00,4'd8},           // R8
        '{8'h26,8'h00,2'd1,1'b1,3'd4,1'b0,3'd0,40'h0,1'b0,1'b0,8'h00,4'd8},           // R8
        '{8'h30,8'h00,2'd2,1'b1,3'd4,1'b0,3'd0,40'h0,1'b0,1'b0,8'h00,4'd8},           // R8
        '{8'h52,8'h00,2'd1,1'b1,3'd1,1'b1,3'd2,40'h0000000044,1'b0,1'b0,8'h00,4'd8},  // R8
        '{8'h30,8'h00,2'd2,1'b1,3'd3,1'b0,3'd0,40'h0,1'b1,1'b0,8'h00,4'd6},           // R6
        '{8'h93,8'h20,2'd2,1'b1,3'd4,1'b0,3'd0,40'h0,1'b0,1'b0,8'h00,4'd9},           // R9
        '{8'h52,8'h00,2'd1,1'b1,3'd1,1'b1,3'd2,40'h0000000044,1'b0,1'b0,8'h00,4'd2},  // R2
        '{8'h95,8'h20,2'd2,1'b1,3'd4,1'b0,3'd0,40'h0,1'b0,1'b0,8'h00,4'd9}            // R9
    };

    task automatic send_frame(input logic [7:0] b0, input logic [7:0] b1,
                              input int n, input logic ok);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = (i == 0) ? b0 : ((i == 1) ? b1 : 8'h5A);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_end   = 1'b1;
        rx_ok    = ok;
        @(negedge clk);
        rx_end   = 1'b0;
        rx_ok    = 1'b0;
    endtask

    task automatic compare(input vec_t v, input string tag);
        logic bad;
        n_checks++;
        bad = (state !== v.st) || (rsp_valid !== v.rv) || (mem_req !== v.mreq) ||
              (v.rv && (rsp_len !== v.rlen || rsp_data !== v.rdata)) ||
              (v.mreq && (mem_write !== v.mwr || mem_addr !== v.maddr));
        if (bad) begin
            n_fail++;
            $display("FAIL %s R%0d: st=%0d rv=%0d len=%0d data=%h mreq=%0d wr=%0d addr=%h | exp st=%0d rv=%0d len=%0d data=%h mreq=%0d wr=%0d addr=%h",
                     tag, v.req, state, rsp_valid, rsp_len, rsp_data, mem_req, mem_write,
                     mem_addr, v.st, v.rv, v.rlen, v.rdata, v.mreq, v.mwr, v.maddr);
        end
    endtask

    task automatic run(input logic [7:0] b0, input logic [7:0] b1, input int n,
                       input logic ok, input vec_t exp, input string tag);
        send_frame(b0, b1, n, ok);
        compare(exp, tag);
    endtask

    function automatic vec_t ex(input logic [2:0] st, input logic rv, input logic [2:0] rlen,
                                input logic [39:0] rdata, input logic mreq, input logic mwr,
                                input logic [7:0] maddr, input logic [3:0] req);
        vec_t v;
        v = '0;
        v.st = st; v.rv = rv; v.rlen = rlen; v.rdata = rdata;
        v.mreq = mreq; v.mwr = mwr; v.maddr = maddr; v.req = req;
        return v;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        compare(ex(3'd0, 1'b0, 3'd0, 40'h0, 1'b0, 1'b0, 8'h00, 4'd1), "reset held R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare(ex(3'd0, 1'b0, 3'd0, 40'h0, 1'b0, 1'b0, 8'h00, 4'd1), "after reset R1");
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R10: run hung, actual running expected done");
            finish_run();
        end
    end

    initial begin
        do_reset();

        for (int i = 0; i < NV; i++) begin
            send_frame(VECS[i].b0, VECS[i].b1, int'(VECS[i].n), VECS[i].ok);
            compare(VECS[i], $sformatf("vector %0d", i));
        end

        // R10: pulses last a single cycle
        @(negedge clk);
        compare(ex(3'd4, 1'b0, 3'd0, 40'h0, 1'b0, 1'b0, 8'h00, 4'd10), "pulse drop R10");

        // Reset clears the halted history (R1, R9)
        do_reset();
        run(8'h26, 8'h00, 1, 1'b1, ex(3'd1, 1'b1, 3'd2, 40'h44, 1'b0, 1'b0, 8'h00, 4'd2), "request R2");
        run(8'h93, 8'h20, 2, 1'b0, ex(3'd0, 1'b0, 3'd0, 40'h0, 1'b0, 1'b0, 8'h00, 4'd9), "bad check flag R9");
        run(8'h93, 8'h20, 2, 1'b1, ex(3'd0, 1'b0, 3'd0, 40'h0, 1'b0, 1'b0, 8'h00, 4'd2), "idle ignores R2");
        run(8'h26, 8'h00, 2, 1'b1, ex(3'd0, 1'b0, 3'd0, 40'h0, 1'b0, 1'b0, 8'h00, 4'd11), "two-byte request R11");
        run(8'h26, 8'h00, 1, 1'b1, ex(3'd1, 1'b1, 3'd2, 40'h44, 1'b0, 1'b0, 8'h00, 4'd2), "request again R2");
        run(8'h93, 8'h67, 2, 1'b1, ex(3'd1, 1'b1, 3'd1, 40'hBF, 1'b0, 1'b0, 8'h00, 4'd3), "last-byte fragment R3");
        run(8'h93, 8'h10, 2, 1'b1, ex(3'd0, 1'b0, 3'd0, 40'h0, 1'b0, 1'b0, 8'h00, 4'd9), "count out of range R9");
        run(8'h52, 8'h00, 1, 1'b1, ex(3'd1, 1'b1, 3'd2, 40'h44, 1'b0, 1'b0, 8'h00, 4'd2), "wake from idle R2");
        run(8'h93, 8'h70, 3, 1'b1, ex(3'd2, 1'b1, 3'd1, 40'h04, 1'b0, 1'b0, 8'h00, 4'd4), "select long frame R4");
        run(8'h95, 8'h50, 2, 1'b1, ex(3'd2, 1'b1, 3'd2, 40'h4466, 1'b0, 1'b0, 8'h00, 4'd5), "level two fragment R5");
        run(8'h30, 8'h00, 2, 1'b1, ex(3'd3, 1'b0, 3'd0, 40'h0, 1'b1, 1'b0, 8'h00, 4'd6), "read skips level two R6");
        run(8'hA2, 8'h07, 3, 1'b1, ex(3'd3, 1'b0, 3'd0, 40'h0, 1'b1, 1'b1, 8'h07, 4'd7), "write hand-off R7 R11");
        run(8'h26, 8'h00, 1, 1'b1, ex(3'd0, 1'b0, 3'd0, 40'h0, 1'b0, 1'b0, 8'h00, 4'd9), "short frame active R9");

        done = 1'b1;
        finish_run();
    end
endmodule